// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is the slave side of a serial peripheral link. It lets an external master read and write a bank of 8-bit registers that lives elsewhere in the chip. The chip-select, serial clock and serial data pins are oversampled in the system clock domain, so no logic runs on the serial clock itself. The block issues one-cycle strobes on a plain synchronous register port, which carries an address, write data, read data and separate read and write strobes.

Every transaction opens with a command byte. Its first bit is the direction, 1 for read and 0 for write. Its second bit asks for the address to step after each data byte. The six address bits follow, most significant first. One or more data bytes come after the command. A burst keeps the same address or steps it by one per byte, as the command asks, and the step wraps from 63 to 0. Read data leaves on falling serial-clock edges for the master to capture on rising ones. It appears either on a dedicated output pin (4-wire) or on the driver of the shared data pin (3-wire), as chosen by a mode input.

The byte sequencer is a five-state machine:
- IDLE is held while chip-select is high.
- CMD collects the command byte. After its eighth bit the machine moves to LOAD for a read or to DATA for a write.
- DATA shifts a data byte. After its eighth bit the machine moves to NEXT.
- NEXT issues the write strobe on a write and steps the address if asked. It then moves to LOAD for a read or back to DATA for a write.
- LOAD issues the read strobe, captures the read data into the shifter and moves to DATA.
- A rise of chip-select in any state sends the machine back to IDLE.

Top module: `spi_regport_slave`

## Requirements
- R1: The command byte is decoded as serial bit 0 = direction (1 read, 0 write), bit 1 = address step, bits 2..7 = address bits 5..0. A 16-clock write puts the received byte, MSB first, on `reg_wdata` at the commanded `reg_addr`.
- R2: `reg_we` pulses for exactly one system clock after each complete received data byte, with `reg_addr` and `reg_wdata` valid in that cycle.
- R3: During a read, `reg_re` pulses for one clock after the command byte and after each complete data byte, which gives bytes+1 pulses per completed read. `reg_rdata` is taken in the pulse cycle and sent MSB first, one bit per falling serial clock.
- R4: The selected output enable is low during serial bits 0..7 of a read and high from the falling edge that starts bit 8.
- R5: Both output enables are low while chip-select is high and throughout a write.
- R6: With the step bit set, the address rises by one after each data byte and wraps from 63 to 0.
- R7: With the step bit clear, every data byte of a burst uses the commanded address.
- R8: A chip-select rise in the middle of a byte aborts the transfer. The partial byte produces no write strobe, and the next transaction starts at bit 0.
- R9: When `wire3_en` is 1, read data is driven on `spi_sio_out` with `spi_sio_oe` and `spi_miso_oe` stays low. When it is 0, the roles are swapped.
- R10: `reg_we` and `reg_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_sck | input | 1 | Serial clock, idles high |
| spi_mosi | input | 1 | Serial data in (shared pin input in 3-wire mode) |
| wire3_en | input | 1 | 1 selects 3-wire operation |
| spi_miso | output | 1 | Dedicated serial data out (4-wire) |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| spi_sio_out | output | 1 | Shared data pin driver value (3-wire) |
| spi_sio_oe | output | 1 | Output enable for the shared data pin |
| reg_addr | output | 6 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Write strobe, one clock |
| reg_re | output | 1 | Read strobe, one clock |
| reg_rdata | input | 8 | Register read data, valid in the `reg_re` cycle |

## Verification
The hardest condition to reach is a chip-select rise that lands inside a data byte. At that point the sequencer holds a partly filled shift register that must never reach the register port. The master model in the bench stops clocking after an arbitrary bit count, which produces an abort four bits into a write byte and another three bits into the second byte of a read burst. The bench then reads back the targeted register and counts the read strobes, which shows that nothing was committed and that the next command starts cleanly. The wrap of a stepping burst is reached by starting bursts at address 62.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_NEXT,
        ST_LOAD
    } spi_seq_e;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int             W      = 3,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[g] <= INIT;
                end else if (g == 0) begin
                    pipe[g] <= din;
                end else begin
                    pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_regport_seq.sv
module spi_regport_seq
    import spi_regport_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_q,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          sdi_q,
    input  logic [DW-1:0] reg_rdata,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    output logic          so_bit,
    output logic          drive
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    spi_seq_e      state, nxt_state;
    logic [CW-1:0] bitcnt;
    logic [DW-1:0] rx, tx;
    logic [AW-1:0] addr_q;
    logic          rd_q, inc_q, fresh, drive_q;
    logic          byte_done;

    assign byte_done = sck_rise && (bitcnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // next-state logic
    always_comb begin
        nxt_state = state;
        if (cs_q) begin
            nxt_state = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt_state = ST_CMD;
                ST_CMD:  if (byte_done) nxt_state = rx[DW-2] ? ST_LOAD : ST_DATA;
                ST_DATA: if (byte_done) nxt_state = ST_NEXT;
                ST_NEXT: nxt_state = rd_q ? ST_LOAD : ST_DATA;
                ST_LOAD: nxt_state = ST_DATA;
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        reg_we    = (state == ST_NEXT) && !rd_q;
        reg_re    = (state == ST_LOAD);
        reg_addr  = addr_q;
        reg_wdata = rx;
        so_bit    = tx[DW-1];
        drive     = drive_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            rx      <= '0;
            tx      <= '0;
            addr_q  <= '0;
            rd_q    <= 1'b0;
            inc_q   <= 1'b0;
            fresh   <= 1'b0;
            drive_q <= 1'b0;
        end else if (cs_q || state == ST_IDLE) begin
            bitcnt  <= '0;
            fresh   <= 1'b0;
            drive_q <= 1'b0;
        end else begin
            if (sck_rise && (state == ST_CMD || state == ST_DATA)) begin
                rx     <= {rx[DW-2:0], sdi_q};
                bitcnt <= bitcnt + 1'b1;
            end
            if (state == ST_CMD && byte_done) begin
                rd_q   <= rx[DW-2];
                inc_q  <= rx[DW-3];
                addr_q <= {rx[AW-2:0], sdi_q};
            end
            if (state == ST_NEXT && inc_q) addr_q <= addr_q + 1'b1;
            if (state == ST_LOAD) begin
                tx    <= reg_rdata;
                fresh <= 1'b1;
            end
            if (state == ST_DATA && sck_fall && rd_q) begin
                drive_q <= 1'b1;
                if (fresh) fresh <= 1'b0;
                else       tx    <= {tx[DW-2:0], 1'b0};
            end
        end
    end

    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));
    a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    a_r3_re_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);
    a_r5_quiet_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> !drive_q);
    a_r5_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_CMD && !rd_q) |-> !drive_q);
    a_r6_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NEXT && inc_q) |=> (addr_q == $past(addr_q) + 1'b1));
    a_r7_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NEXT && !inc_q) |=> (addr_q == $past(addr_q)));
endmodule

// File: rtl/spi_regport_slave.sv
module spi_regport_slave #(
    parameter int AW     = 6,
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_cs_n,
    input  logic          spi_sck,
    input  logic          spi_mosi,
    input  logic          wire3_en,
    output logic          spi_miso,
    output logic          spi_miso_oe,
    output logic          spi_sio_out,
    output logic          spi_sio_oe,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);
    logic [2:0] pins_q;
    logic       sck_d;
    logic       so_bit, drive;

    spi_regport_sync #(.W(3), .STAGES(STAGES), .INIT(3'b110)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n, spi_sck, spi_mosi}),
        .dout  (pins_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b1;
        else        sck_d <= pins_q[1];
    end

    spi_regport_seq #(.AW(AW), .DW(DW)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_q      (pins_q[2]),
        .sck_rise  (pins_q[1] && !sck_d),
        .sck_fall  (!pins_q[1] && sck_d),
        .sdi_q     (pins_q[0]),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .so_bit    (so_bit),
        .drive     (drive)
    );

    assign spi_miso    = so_bit;
    assign spi_sio_out = so_bit;
    assign spi_miso_oe = drive && !wire3_en;
    assign spi_sio_oe  = drive && wire3_en;
endmodule

// File: tb/test_spi_regport_slave.sv
`timescale 1ns/1ps
module test_spi_regport_slave;
    localparam int HALF = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, spi_cs_n, spi_sck, spi_mosi, wire3_en;
    logic       spi_miso, spi_miso_oe, spi_sio_out, spi_sio_oe;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       reg_we, reg_re;

    spi_regport_slave i_spi_regport_slave (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .wire3_en(wire3_en), .spi_miso(spi_miso),
        .spi_miso_oe(spi_miso_oe), .spi_sio_out(spi_sio_out), .spi_sio_oe(spi_sio_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    logic [7:0] bank [64];
    assign reg_rdata = bank[reg_addr];

    int checks = 0;
    int fails  = 0;
    int re_cnt = 0;
    int cs_hi  = 0;
    logic [5:0] exp_wa [$];
    logic [7:0] exp_wd [$];
    logic [7:0] wbuf [8];
    logic [5:0] pop_a;
    logic [7:0] pop_d;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock reference comparison of the register port and pin drivers
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_re) re_cnt++;
            chk(!(reg_we && reg_re), "R10 strobes together", {reg_we, reg_re}, 0);
            if (reg_we) begin
                if (exp_wa.size() == 0) begin
                    chk(1'b0, "R8 unexpected write strobe", reg_addr, 0);
                end else begin
                    pop_a = exp_wa.pop_front();
                    pop_d = exp_wd.pop_front();
                    chk(reg_addr == pop_a, "R2 write address", reg_addr, pop_a);
                    chk(reg_wdata == pop_d, "R1 write data", reg_wdata, pop_d);
                end
                bank[reg_addr] = reg_wdata;
            end
            if (spi_cs_n) cs_hi++; else cs_hi = 0;
            if (cs_hi > 4)
                chk(!spi_miso_oe && !spi_sio_oe, "R5 driven while deselected",
                    {spi_miso_oe, spi_sio_oe}, 0);
        end
    end

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic txn(input bit rd, input bit inc, input logic [5:0] addr,
                       input int nbits, input string tag);
        logic [7:0] cmd;
        logic [7:0] rbyte;
        int         full;
        cmd   = {rd, inc, addr};
        rbyte = '0;
        full  = (nbits >= 8) ? (nbits - 8) / 8 : 0;
        if (!rd) begin
            for (int k = 0; k < full; k++) begin
                exp_wa.push_back(inc ? addr + 6'(k) : addr);
                exp_wd.push_back(wbuf[k]);
            end
        end
        re_cnt   = 0;
        spi_cs_n = 1'b0;
        half();
        for (int b = 0; b < nbits; b++) begin
            logic bv, oe_sel, oe_oth, dv;
            if (b < 8)    bv = cmd[7-b];
            else if (!rd) bv = wbuf[(b-8)/8][7-((b-8)%8)];
            else          bv = 1'b0;
            spi_sck  = 1'b0;
            spi_mosi = bv;
            half();
            spi_sck = 1'b1;
            oe_sel = wire3_en ? spi_sio_oe : spi_miso_oe;
            oe_oth = wire3_en ? spi_miso_oe : spi_sio_oe;
            dv     = wire3_en ? spi_sio_out : spi_miso;
            chk(oe_sel == (rd && b >= 8), "R4 output enable timing", oe_sel, rd && b >= 8);
            chk(oe_oth == 1'b0, "R9 unselected pin driven", oe_oth, 0);
            if (rd && b >= 8) begin
                rbyte = {rbyte[6:0], dv};
                if ((b - 8) % 8 == 7) begin
                    int k;
                    logic [7:0] e;
                    k = (b - 8) / 8;
                    e = bank[inc ? addr + 6'(k) : addr];
                    chk(rbyte == e, tag, rbyte, e);
                end
            end
            half();
        end
        half();
        spi_cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
        chk(exp_wa.size() == 0, "R2 missing write strobes", exp_wa.size(), 0);
        chk(re_cnt == (rd && nbits >= 8 ? full + 1 : 0), "R3 read strobe count",
            re_cnt, rd && nbits >= 8 ? full + 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) bank[i] = 8'(i * 7 + 3);
        rst_n = 1'b0; spi_cs_n = 1'b1; spi_sck = 1'b1; spi_mosi = 1'b0; wire3_en = 1'b0;
        repeat (5) @(negedge clk);
        chk(!reg_we && !reg_re && !spi_miso_oe && !spi_sio_oe, "R5 reset state",
            {reg_we, reg_re, spi_miso_oe, spi_sio_oe}, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);

        // R1: single write, then R3: single read back
        wbuf[0] = 8'hA5;
        txn(1'b0, 1'b0, 6'h15, 16, "R1");
        txn(1'b1, 1'b0, 6'h15, 16, "R3 single read data");

        // R6: stepping burst write and read across the 63->0 wrap
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        txn(1'b0, 1'b1, 6'd62, 8 + 32, "R6");
        txn(1'b1, 1'b1, 6'd62, 8 + 32, "R6 stepping read data");

        // R7: fixed-address burst write and read
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3; wbuf[2] = 8'h0F;
        txn(1'b0, 1'b0, 6'd10, 8 + 24, "R7");
        chk(bank[10] == 8'h0F, "R7 last byte kept at fixed address", bank[10], 8'h0F);
        txn(1'b1, 1'b0, 6'd10, 8 + 24, "R7 fixed read data");

        // R8: abort four bits into a write byte, then read the target back
        wbuf[0] = 8'hFF;
        txn(1'b0, 1'b0, 6'd20, 12, "R8");
        txn(1'b1, 1'b0, 6'd20, 16, "R8 register untouched after abort");

        // R8: abort a read burst three bits into its second byte, then read again
        txn(1'b1, 1'b1, 6'd5, 8 + 8 + 3, "R8 data before read abort");
        txn(1'b1, 1'b1, 6'd6, 8 + 16, "R8 clean read after abort");

        // R9: 3-wire mode read burst and write
        wire3_en = 1'b1;
        repeat (4) @(negedge clk);
        txn(1'b1, 1'b1, 6'd62, 8 + 16, "R9 3-wire read data");
        wbuf[0] = 8'h96;
        txn(1'b0, 1'b0, 6'd33, 16, "R9");
        txn(1'b1, 1'b0, 6'd33, 16, "R9 3-wire read back");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule